// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

A synthesizable behavioural model of a single-ported synchronous SRAM. Reads and writes share one two-stage pipeline, so the data bus can switch from write data to read data on adjacent cycles without an idle slot. Each access is started by a load cycle that carries an address, the operation, the per-lane write strobes and the chip-select terms. Follow-on advance cycles walk a 2-bit burst counter through the aligned group of four words. Each advance cycle repeats the operation chosen by the last load.

A clock enable freezes the whole pipeline for as many cycles as it is held off. A sleep input does the same and also turns the output drivers off. An asynchronous output enable gates only the data drivers. The bidirectional bus is modelled as a data input, a data output and a drive-enable flag.

Top module: `zbt_sram`

## Requirements
- R1: After reset the pipeline is empty, `dq_oe_o` is low and `dq_o` is zero.
- R2: The chip is selected only on a load cycle (`adv_ld_i` low) with `ce1_ni` low, `ce2_ni` low and `ce3_i` high. Any other load is a deselect: no array access, `dq_oe_o` low after the second enabled edge that follows, and advance cycles after it have no effect.
- R3: A selected read load drives its word on `dq_o`, with `dq_oe_o` high, after the second enabled clock edge that follows the load edge.
- R4: A write takes `dq_i` at the second enabled edge after its address edge. Strobe `bw_ni[i]` low writes lane i (bits 8i+7..8i). Lanes whose strobe is high keep their old contents.
- R5: On an advance cycle the low two address bits step by one modulo 4 from the loaded value, and the upper bits stay fixed. The operation of the last load repeats. `we_ni` and the chip-enable inputs are ignored. `bw_ni` is taken fresh on every cycle.
- R6: A read loaded on the cycle right after a write to the same address returns the newly written, lane-merged word. The bus is undriven during the write's data slot and driven in the very next slot.
- R7: While `cke_ni` is high, clock edges are ignored. No input is captured and the pipeline, burst counter and outputs all hold. The access completes that many cycles later.
- R8: While `sleep_i` is high, all other inputs are ignored, no access occurs, the array keeps its contents, `dq_oe_o` is low, and the pipeline holds.
- R9: `oe_ni` high forces `dq_oe_o` low with no clock edge needed. Setting it low again restores the held read word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address, captured on load cycles |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_ni | input | 1 | Chip enable, active low |
| ce3_i | input | 1 | Chip enable, active high |
| adv_ld_i | input | 1 | High advances the burst, low loads a new address |
| we_ni | input | 1 | Low selects write on a load cycle |
| bw_ni | input | LANES | Per-lane write strobes, active low |
| cke_ni | input | 1 | Clock enable, active low |
| sleep_i | input | 1 | Sleep, active high |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| dq_i | input | LANES*LANE_W | Write data from the bus |
| dq_o | output | LANES*LANE_W | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
Every command is issued in a bench slot that starts 1 ns after a rising edge. A read word is due three slots after its load slot. The write data for the same access is driven two slots after the load. The bench places each expected bus value into a ring indexed by the slot where it is due, and compares at that slot's start, before new inputs are applied. In the stall and sleep scenarios the due slot moves by one for every frozen edge, and the hold checks sample the slot just after a frozen edge. Output-enable and sleep gating are sampled 1 ns after the input moves, with no clock edge in between.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int unsigned BURST_W = 2;
  typedef enum logic {OP_READ = 1'b0, OP_WRITE = 1'b1} op_e;
endpackage

// File: rtl/zbt_issue.sv
module zbt_issue import zbt_pkg::*; #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_i,
  input  logic              adv_i,
  input  logic              wr_i,
  input  logic [LANES-1:0]  be_i,
  output logic              req_vld_o,
  output op_e               req_op_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LANES-1:0]  req_be_o
);
  localparam int unsigned HI_W = ADDR_W - BURST_W;

  logic               act_q;
  op_e                op_q;
  logic [HI_W-1:0]    base_q;
  logic [BURST_W-1:0] cnt_q, cnt_inc;

  assign cnt_inc = BURST_W'(cnt_q + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      op_q       <= OP_READ;
      base_q     <= '0;
      cnt_q      <= '0;
      req_vld_o  <= 1'b0;
      req_op_o   <= OP_READ;
      req_addr_o <= '0;
      req_be_o   <= '0;
    end else if (en_i) begin
      req_be_o <= be_i;
      if (!adv_i) begin
        act_q      <= ce_i;
        op_q       <= wr_i ? OP_WRITE : OP_READ;
        base_q     <= addr_i[ADDR_W-1:BURST_W];
        cnt_q      <= addr_i[BURST_W-1:0];
        req_vld_o  <= ce_i;
        req_op_o   <= wr_i ? OP_WRITE : OP_READ;
        req_addr_o <= addr_i;
      end else begin
        // burst step: wrap inside the aligned group
        cnt_q      <= cnt_inc;
        req_vld_o  <= act_q;
        req_op_o   <= op_q;
        req_addr_o <= {base_q, cnt_inc};
      end
    end
  end
endmodule

// File: rtl/zbt_lane_ram.sv
module zbt_lane_ram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram import zbt_pkg::*; #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    ce1_ni,
  input  logic                    ce2_ni,
  input  logic                    ce3_i,
  input  logic                    adv_ld_i,
  input  logic                    we_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic                    cke_ni,
  input  logic                    sleep_i,
  input  logic                    oe_ni,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic              en, ce_ok;
  logic              req_vld;
  op_e               req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [LANES-1:0]  req_be;

  logic              s2_vld;
  op_e               s2_op;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_be;
  logic              s2_rd, s2_wr;
  logic              rd_vld_q;
  logic [DATA_W-1:0] rd_data;

  assign en    = !cke_ni && !sleep_i;
  assign ce_ok = !ce1_ni && !ce2_ni && ce3_i;

  zbt_issue #(.ADDR_W(ADDR_W), .LANES(LANES)) u_issue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .addr_i     (addr_i),
    .ce_i       (ce_ok),
    .adv_i      (adv_ld_i),
    .wr_i       (!we_ni),
    .be_i       (~bw_ni),
    .req_vld_o  (req_vld),
    .req_op_o   (req_op),
    .req_addr_o (req_addr),
    .req_be_o   (req_be)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld   <= 1'b0;
      s2_op    <= OP_READ;
      s2_addr  <= '0;
      s2_be    <= '0;
      rd_vld_q <= 1'b0;
    end else if (en) begin
      s2_vld   <= req_vld;
      s2_op    <= req_op;
      s2_addr  <= req_addr;
      s2_be    <= req_be;
      rd_vld_q <= s2_rd;
    end
  end

  // both ops touch the array in stage 2, so read-after-write needs no bypass
  assign s2_rd = s2_vld && (s2_op == OP_READ);
  assign s2_wr = s2_vld && (s2_op == OP_WRITE);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    zbt_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (en && s2_wr && s2_be[i]),
      .rd_i    (en && s2_rd),
      .addr_i  (s2_addr),
      .wdata_i (dq_i[i*LANE_W +: LANE_W]),
      .rdata_o (rd_data[i*LANE_W +: LANE_W])
    );
  end

  assign dq_o    = rd_data;
  assign dq_oe_o = rd_vld_q && !oe_ni && !sleep_i;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_ni,
  input logic              sleep_i,
  input logic              oe_ni,
  input logic              adv_ld_i,
  input logic              we_ni,
  input logic              ce1_ni,
  input logic              ce2_ni,
  input logic              ce3_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe_o,
  input logic              req_vld,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rd_vld_q
);
  logic en, sel, rd1_q, rd2_q, ds1_q, ds2_q;
  assign en  = !cke_ni && !sleep_i;
  assign sel = !ce1_ni && !ce2_ni && ce3_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd1_q <= 1'b0; rd2_q <= 1'b0; ds1_q <= 1'b0; ds2_q <= 1'b0;
    end else if (en) begin
      rd1_q <= !adv_ld_i && sel && we_ni;
      ds1_q <= !adv_ld_i && !sel;
      rd2_q <= rd1_q;
      ds2_q <= ds1_q;
    end
  end

  assert_deselect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && ds2_q) |=> !dq_oe_o);
  assert_ce_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !adv_ld_i && !sel) |=> !req_vld);
  assert_read_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && rd2_q) |=> rd_vld_q);
  assert_burst_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && adv_ld_i && req_vld) |=>
      (req_addr[ADDR_W-1:2] == $past(req_addr[ADDR_W-1:2])) &&
      (req_addr[1:0] == 2'($past(req_addr[1:0]) + 2'd1)));
  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> ($stable(dq_o) && $stable(rd_vld_q)));
  assert_sleep_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(dq_o) && $stable(rd_vld_q)));
  assert_oe_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ni || sleep_i) |-> !dq_oe_o);
endmodule

bind zbt_sram zbt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cke_ni   (cke_ni),
  .sleep_i  (sleep_i),
  .oe_ni    (oe_ni),
  .adv_ld_i (adv_ld_i),
  .we_ni    (we_ni),
  .ce1_ni   (ce1_ni),
  .ce2_ni   (ce2_ni),
  .ce3_i    (ce3_i),
  .dq_o     (dq_o),
  .dq_oe_o  (dq_oe_o),
  .req_vld  (req_vld),
  .req_addr (req_addr),
  .rd_vld_q (rd_vld_q)
);

// File: tb/sim_zbt_sram.sv
`timescale 1ns/1ps
module sim_zbt_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        ce1_n = 1'b1, ce2_n = 1'b0, ce3 = 1'b1;
  logic        adv = 1'b0, we_n = 1'b1;
  logic [3:0]  bw_n = 4'hF;
  logic        cke_n = 1'b0, sleep = 1'b0, oe_n = 1'b0;
  logic [31:0] dq_i = '0;
  logic [31:0] dq_o;
  logic        dq_oe;

  int n_chk = 0, n_bad = 0, slot = 0;
  bit          pend  [16];
  bit          p_oe  [16];
  logic [31:0] p_dat [16];
  string       p_req [16];
  logic [31:0] ref_mem [256];

  always #4 clk = ~clk;

  zbt_sram u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ce1_ni(ce1_n), .ce2_ni(ce2_n),
    .ce3_i(ce3), .adv_ld_i(adv), .we_ni(we_n), .bw_ni(bw_n), .cke_ni(cke_n),
    .sleep_i(sleep), .oe_ni(oe_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe)
  );

  function automatic logic [31:0] merge(logic [31:0] old_w, logic [31:0] new_w, logic [3:0] bwn);
    logic [31:0] r = old_w;
    for (int i = 0; i < 4; i++) if (!bwn[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
    return r;
  endfunction

  task automatic chk(string req, bit oe_exp, logic [31:0] d_exp, bit use_d);
    n_chk++;
    if (dq_oe !== oe_exp || (use_d && dq_o !== d_exp)) begin
      n_bad++;
      $display("FAIL %s: oe=%0b dq=%h expected oe=%0b dq=%h", req, dq_oe, dq_o, oe_exp, d_exp);
    end
  endtask

  task automatic expect_at(int delta, bit oe_exp, logic [31:0] d, string req);
    int k = (slot + delta) % 16;
    pend[k] = 1'b1; p_oe[k] = oe_exp; p_dat[k] = d; p_req[k] = req;
  endtask

  task automatic tick();
    int k;
    @(posedge clk); #1;
    slot++;
    k = slot % 16;
    if (pend[k]) begin
      chk(p_req[k], p_oe[k], p_dat[k], p_oe[k]);
      pend[k] = 1'b0;
    end
  endtask

  task automatic cmd_idle();
    adv = 1'b0; ce1_n = 1'b1; ce2_n = 1'b0; ce3 = 1'b1; we_n = 1'b1; bw_n = 4'hF;
  endtask

  task automatic cmd_load(logic [7:0] a, bit wr, logic [3:0] bwn);
    adv = 1'b0; ce1_n = 1'b0; ce2_n = 1'b0; ce3 = 1'b1; we_n = !wr; addr = a; bw_n = bwn;
  endtask

  task automatic cmd_adv(logic [3:0] bwn);
    adv = 1'b1; bw_n = bwn;
  endtask

  task automatic do_write(logic [7:0] a, logic [31:0] d);
    cmd_load(a, 1'b1, 4'h0); tick();
    cmd_idle(); tick();
    dq_i = d; tick();
    tick();
    ref_mem[a] = d;
  endtask

  task automatic do_read(logic [7:0] a, string req);
    cmd_load(a, 1'b0, 4'hF); expect_at(3, 1'b1, ref_mem[a], req); tick();
    cmd_idle(); tick(); tick(); tick();
  endtask

  task automatic t_reset();
    chk("R1 reset", 1'b0, 32'h0, 1'b1);
  endtask

  task automatic t_back_to_back();
    logic [31:0] e;
    cmd_load(8'h10, 1'b1, 4'h0); tick();
    cmd_load(8'h10, 1'b0, 4'hF); expect_at(3, 1'b1, 32'hA1B2C3D4, "R6 R3 read after write"); tick();
    dq_i = 32'hA1B2C3D4; cmd_idle(); expect_at(1, 1'b0, '0, "R6 write slot undriven"); tick();
    tick(); tick();
    ref_mem[8'h10] = 32'hA1B2C3D4;
    e = merge(ref_mem[8'h10], 32'h55667788, 4'b1010);
    cmd_load(8'h10, 1'b1, 4'b1010); tick();
    cmd_load(8'h10, 1'b0, 4'hF); expect_at(3, 1'b1, e, "R4 lane merge"); tick();
    dq_i = 32'h55667788; cmd_idle(); tick();
    tick(); tick();
    ref_mem[8'h10] = e;
  endtask

  task automatic t_burst();
    cmd_load(8'h22, 1'b1, 4'h0); tick();
    cmd_adv(4'h0); we_n = 1'b1; ce1_n = 1'b1; tick();
    cmd_adv(4'h0); dq_i = 32'h2222_0000; tick();
    cmd_adv(4'h0); dq_i = 32'h2323_1111; tick();
    cmd_idle(); dq_i = 32'h2020_2222; tick();
    cmd_idle(); dq_i = 32'h2121_3333; tick();
    tick();
    ref_mem[8'h22] = 32'h2222_0000; ref_mem[8'h23] = 32'h2323_1111;
    ref_mem[8'h20] = 32'h2020_2222; ref_mem[8'h21] = 32'h2121_3333;
    cmd_load(8'h23, 1'b0, 4'hF); expect_at(3, 1'b1, ref_mem[8'h23], "R5 burst 0"); tick();
    cmd_adv(4'hF); we_n = 1'b0; ce1_n = 1'b1; expect_at(3, 1'b1, ref_mem[8'h20], "R5 burst wrap"); tick();
    cmd_adv(4'hF); expect_at(3, 1'b1, ref_mem[8'h21], "R5 burst 2"); tick();
    cmd_adv(4'hF); expect_at(3, 1'b1, ref_mem[8'h22], "R5 burst 3"); tick();
    cmd_idle(); expect_at(3, 1'b0, '0, "R5 burst end"); tick();
    tick(); tick();
  endtask

  task automatic t_stall();
    cmd_load(8'h10, 1'b0, 4'hF);
    expect_at(3, 1'b0, '0, "R7 stalled not yet");
    expect_at(4, 1'b1, ref_mem[8'h10], "R7 delayed read"); tick();
    cke_n = 1'b1; cmd_load(8'h40, 1'b1, 4'h0); dq_i = 32'hDEADBEEF; tick();
    cke_n = 1'b0; cmd_idle(); tick();
    tick();
    cke_n = 1'b1; expect_at(1, 1'b1, ref_mem[8'h10], "R7 output held"); tick();
    cke_n = 1'b0; expect_at(1, 1'b0, '0, "R7 resume"); tick();
    tick(); tick();
  endtask

  task automatic t_deselect();
    cmd_load(8'h40, 1'b1, 4'h0); ce2_n = 1'b1; expect_at(3, 1'b0, '0, "R2 ce2 deselect"); tick();
    cmd_adv(4'h0); expect_at(3, 1'b0, '0, "R2 advance after deselect"); tick();
    cmd_load(8'h41, 1'b0, 4'hF); ce3 = 1'b0; dq_i = 32'hBAD0BAD0; expect_at(3, 1'b0, '0, "R2 ce3 deselect"); tick();
    cmd_idle(); dq_i = 32'hBAD1BAD1; tick();
    tick(); tick(); tick();
    do_read(8'h40, "R2 no write on deselect");
    do_read(8'h41, "R2 no write on advance");
  endtask

  task automatic t_sleep();
    cmd_load(8'h10, 1'b0, 4'hF); tick();
    cmd_idle(); tick();
    tick();
    chk("R8 before sleep", 1'b1, ref_mem[8'h10], 1'b1);
    sleep = 1'b1; cmd_load(8'h40, 1'b1, 4'h0); dq_i = 32'hFACEFACE; #1;
    chk("R8 asleep undriven", 1'b0, '0, 1'b0);
    tick(); tick();
    sleep = 1'b0; cmd_idle(); #1;
    chk("R8 wake holds word", 1'b1, ref_mem[8'h10], 1'b1);
    tick();
    chk("R8 pipeline resumes", 1'b0, '0, 1'b0);
    tick(); tick();
    do_read(8'h40, "R8 array kept");
  endtask

  task automatic t_oe();
    cmd_load(8'h10, 1'b0, 4'hF); tick();
    cmd_idle(); tick();
    tick();
    oe_n = 1'b1; #1;
    chk("R9 oe off", 1'b0, '0, 1'b0);
    oe_n = 1'b0; #1;
    chk("R9 oe on", 1'b1, ref_mem[8'h10], 1'b1);
    tick(); tick();
  endtask

  bit done = 1'b0;

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    do_write(8'h40, 32'h4040_4040);
    do_write(8'h41, 32'h4141_4141);
    t_back_to_back();
    t_burst();
    t_stall();
    t_deselect();
    t_sleep();
    t_oe();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule